// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block funnels 64 level-sensitive interrupt lines into one outstanding request toward a processor. The request is a valid flag and a 6-bit line number. Lines 0 to 31 come from expansion-bus slots and share mapping registers in groups of four, so there are eight slot registers. Lines 32 to 63 come from on-board sources and each has a mapping register of its own. A line can raise a request only while the enable bit of its mapping register is set.

Only one request is held at a time, and it stays asserted until software retires it. Software retires it through a per-group clear window, through a per-line clear window, or by disabling the mapping register that owns it. When nothing is held, the controller picks the lowest-numbered line that is both pending and enabled. A slot line whose level rises while its mapping is enabled takes over at once, even if another request is held. An on-board line never displaces a held request.

The raw lines are sampled into a pending vector every clock. A fresh selection therefore appears on the outputs on the second clock edge after a line rises. Register writes and clears act on the edge where the write is presented.

Top module: `irq_funnel`

## Requirements
- R1: After reset, req_valid is 0, every enable bit is 0, and the pending vector is empty.
- R2: A mapping register reads back as {enable, fixed bits 30:0}. A write changes only bit 31. The fixed bits of slot register i are 0x7C0 | (i << 2). The fixed bits of on-board register i are 0x7E0 + i.
- R3: Slot line n is enabled by slot register n/4, which is at address 0x0C00 + 8*(n/4). On-board line n is enabled by on-board register n-32, which is at address 0x1000 + 8*(n-32). A held request always belongs to an enabled register.
- R4: With no request held, the lowest-numbered line that is both pending and enabled becomes the request two clock edges after it is raised. A line that is pending but not enabled is ignored.
- R5: A held request stays valid with the same number while no register write occurs and no enabled slot line rises, even after its line drops.
- R6: A rising slot line whose mapping is enabled replaces any held request on the next selection. If several rise together, the lowest-numbered one wins.
- R7: A rising on-board line never replaces a held request, including one with a higher number.
- R8: A write to 0x1400 + 32*g (g = address bits 7:5) clears the held request only if it is a slot line with number/4 equal to g.
- R9: A write to 0x1800 + 8*k (k = address bits 7:3) clears the held request only if its number is 32 + k. A line that is still pending and enabled is selected again in the same cycle.
- R10: Writing a mapping register with bit 31 = 0 clears the held request if the request belongs to that register, and has no effect on a request owned by another register.
- R11: Reads from either clear window, and from unmapped addresses, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Level interrupt lines; 0-31 slot, 32-63 on-board |
| acc_wr_en | input | 1 | Register write strobe |
| acc_addr | input | 16 | Register byte address, used for both reads and writes |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for acc_addr, combinational |
| req_valid | output | 1 | A request is held |
| req_num | output | 6 | Line number of the held request |

## Verification
A table of enable maps and line patterns is applied. It separates a correct lowest-index choice from choices that ignore the enable, take the wrong slot group for a line, or favour the on-board half. In one entry all 64 lines are raised with nothing enabled, to show that pending alone is not enough. Directed sequences raise, drop and clear lines while a request is held. These show the difference between holding a request and rescanning, between slot and on-board takeover, between wrong-window clears and matching ones, and between a disable that hits the owner and one that does not.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int N_SLOT_REG = 8;
  localparam int SLOT_FAN   = 4;
  localparam int N_SLOT     = N_SLOT_REG * SLOT_FAN;
  localparam int N_BOARD    = 32;
  localparam int N_LINE     = N_SLOT + N_BOARD;
  localparam int NUM_W      = $clog2(N_LINE);
  localparam int AW         = 16;
  localparam int DW         = 32;

  typedef struct packed {
    logic             valid;
    logic [NUM_W-1:0] num;
  } req_t;

  // address windows: slot map 0x0C00-0x0C3F, board map 0x1000-0x10FF,
  // slot clear 0x1400-0x14FF, board clear 0x1800-0x18FF
  function automatic logic win_slot_map(input logic [AW-1:0] a);
    return a[15:6] == 10'h030;
  endfunction
  function automatic logic win_board_map(input logic [AW-1:0] a);
    return a[15:8] == 8'h10;
  endfunction
  function automatic logic win_slot_clr(input logic [AW-1:0] a);
    return a[15:8] == 8'h14;
  endfunction
  function automatic logic win_board_clr(input logic [AW-1:0] a);
    return a[15:8] == 8'h18;
  endfunction

  function automatic logic [DW-1:0] slot_fixed(input int i);
    return 32'((32'h1F << 6) | (i << 2));
  endfunction
  function automatic logic [DW-1:0] board_fixed(input int i);
    return 32'(((32'h1F << 6) | 32'h20) + i);
  endfunction
endpackage

// File: rtl/irqf_lowest.sv
module irqf_lowest #(
  parameter int W  = 64,
  parameter int IW = 6
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
    found = |vec;
  end
endmodule

// File: rtl/irqf_maps.sv
module irqf_maps
  import irqf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [N_LINE-1:0] line_en,
  output logic [N_LINE-1:0] line_en_nx,
  output logic [DW-1:0]     rdata
);
  localparam int SI_W = $clog2(N_SLOT_REG);
  localparam int BI_W = $clog2(N_BOARD);

  logic [N_SLOT_REG-1:0] slot_en_q, slot_en_d;
  logic [N_BOARD-1:0]    board_en_q, board_en_d;
  logic [SI_W-1:0]       s_idx;
  logic [BI_W-1:0]       b_idx;

  assign s_idx = addr[3 +: SI_W];
  assign b_idx = addr[3 +: BI_W];

  always_comb begin
    slot_en_d  = slot_en_q;
    board_en_d = board_en_q;
    if (wr_en && win_slot_map(addr))  slot_en_d[s_idx]  = wdata[31];
    if (wr_en && win_board_map(addr)) board_en_d[b_idx] = wdata[31];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_en_q  <= '0;
      board_en_q <= '0;
    end else begin
      slot_en_q  <= slot_en_d;
      board_en_q <= board_en_d;
    end
  end

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot_line
    assign line_en[g]    = slot_en_q[g / SLOT_FAN];
    assign line_en_nx[g] = slot_en_d[g / SLOT_FAN];
  end
  for (genvar g = 0; g < N_BOARD; g++) begin : g_board_line
    assign line_en[N_SLOT + g]    = board_en_q[g];
    assign line_en_nx[N_SLOT + g] = board_en_d[g];
  end

  always_comb begin
    rdata = '0;
    if (win_slot_map(addr))
      rdata = {slot_en_q[s_idx], slot_fixed(int'(s_idx))[30:0]};
    else if (win_board_map(addr))
      rdata = {board_en_q[b_idx], board_fixed(int'(b_idx))[30:0]};
  end

  logic unused_bits;
  assign unused_bits = ^{wdata[30:0], addr[2:0]};
endmodule

// File: rtl/irq_funnel.sv
module irq_funnel
  import irqf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       irq_in,
  input  logic              acc_wr_en,
  input  logic [15:0]       acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              req_valid,
  output logic [5:0]        req_num
);
  logic [N_LINE-1:0] pend_q, prev_q;
  logic [N_LINE-1:0] line_en, line_en_nx;
  req_t              req_q, req_d;

  irqf_maps i_maps (
    .clk(clk), .rst_n(rst_n), .wr_en(acc_wr_en), .addr(acc_addr),
    .wdata(acc_wdata), .line_en(line_en), .line_en_nx(line_en_nx),
    .rdata(acc_rdata)
  );

  // enabled slot lines that rose this cycle
  logic [N_SLOT-1:0] slot_rise;
  logic              rs_found, sc_found;
  logic [NUM_W-1:0]  rs_idx, sc_idx;

  assign slot_rise = pend_q[N_SLOT-1:0] & ~prev_q[N_SLOT-1:0] & line_en_nx[N_SLOT-1:0];

  irqf_lowest #(.W(N_SLOT), .IW(NUM_W)) i_rise_pick (
    .vec(slot_rise), .found(rs_found), .idx(rs_idx)
  );
  irqf_lowest #(.W(N_LINE), .IW(NUM_W)) i_scan_pick (
    .vec(pend_q & line_en_nx), .found(sc_found), .idx(sc_idx)
  );

  logic own_slot, own_board, clear_hit;
  assign own_slot  = req_q.valid && !req_q.num[5];
  assign own_board = req_q.valid && req_q.num[5];

  always_comb begin
    clear_hit = 1'b0;
    if (acc_wr_en) begin
      if (win_slot_clr(acc_addr) && own_slot && req_q.num[4:2] == acc_addr[7:5])
        clear_hit = 1'b1;
      if (win_board_clr(acc_addr) && own_board && req_q.num[4:0] == acc_addr[7:3])
        clear_hit = 1'b1;
      if (win_slot_map(acc_addr) && !acc_wdata[31] && own_slot &&
          req_q.num[4:2] == acc_addr[5:3])
        clear_hit = 1'b1;
      if (win_board_map(acc_addr) && !acc_wdata[31] && own_board &&
          req_q.num[4:0] == acc_addr[7:3])
        clear_hit = 1'b1;
    end
  end

  always_comb begin
    req_d = req_q;
    if (clear_hit) req_d.valid = 1'b0;
    if (rs_found) begin
      req_d.valid = 1'b1;
      req_d.num   = rs_idx;
    end else if (!req_d.valid && sc_found) begin
      req_d.valid = 1'b1;
      req_d.num   = sc_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      pend_q <= irq_in;
      prev_q <= pend_q;
      req_q  <= req_d;
    end
  end

  assign req_valid = req_q.valid;
  assign req_num   = req_q.num;
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [5:0]  req_num,
  input logic [63:0] line_en,
  input logic        slot_rise_any,
  input logic        acc_wr_en,
  input logic [15:0] acc_addr,
  input logic [31:0] acc_rdata
);
  p_req_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> line_en[req_num]);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_wr_en && !slot_rise_any) |=> (req_valid && $stable(req_num)));

  p_preempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_rise_any |=> (req_valid && !req_num[5]));

  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(acc_addr) |-> $stable(acc_rdata[30:0]));

  p_clr_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr[15:8] == 8'h14 || acc_addr[15:8] == 8'h18) |-> acc_rdata == 32'h0);
endmodule

bind irq_funnel irqf_checker i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_num(req_num),
  .line_en(line_en), .slot_rise_any(rs_found), .acc_wr_en(acc_wr_en),
  .acc_addr(acc_addr), .acc_rdata(acc_rdata)
);

// File: tb/test_irq_funnel.sv
module test_irq_funnel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq_in;
  logic        acc_wr_en;
  logic [15:0] acc_addr;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata;
  logic        req_valid;
  logic [5:0]  req_num;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_funnel i_irq_funnel (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .acc_wr_en(acc_wr_en),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .req_valid(req_valid), .req_num(req_num)
  );

  // {slot enables[7:0], board enables[31:0], lines[63:0], exp valid, exp num[5:0]}
  localparam int NV = 7;
  localparam logic [110:0] VEC [NV] = '{
    {8'h04, 32'h0000_0000, 64'h0000_0000_0000_0600, 1'b1, 6'd9},
    {8'h01, 32'h0000_0020, 64'h0000_0120_0000_0000, 1'b1, 6'd37},
    {8'hFF, 32'hFFFF_FFFF, 64'h8000_0002_0000_0000, 1'b1, 6'd33},
    {8'h00, 32'h0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 6'd0},
    {8'h80, 32'h8000_0000, 64'h8000_0000_8000_0000, 1'b1, 6'd31},
    {8'h02, 32'h0000_0000, 64'h0000_0000_0000_0018, 1'b1, 6'd4},
    {8'h01, 32'h0000_0001, 64'h0000_0001_0000_0002, 1'b1, 6'd1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_in = '0; acc_wr_en = 1'b0; acc_addr = '0; acc_wdata = '0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_wr_en = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_wr_en = 1'b0; acc_addr = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_addr = a;
    #1 d = acc_rdata;
  endtask

  task automatic lines(input logic [63:0] v);
    @(negedge clk);
    irq_in = v;
    idle(3);
  endtask

  task automatic chk_req(input string tag, input logic v, input logic [5:0] n);
    check({tag, " valid"}, {31'd0, req_valid}, {31'd0, v});
    if (v) check({tag, " num"}, {26'd0, req_num}, {26'd0, n});
  endtask

  initial begin : watchdog
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b1; irq_in = '0; acc_wr_en = 1'b0; acc_addr = '0; acc_wdata = '0;

    // table walk: R3, R4
    for (int v = 0; v < NV; v++) begin
      do_reset();
      for (int r = 0; r < 8; r++)
        if (VEC[v][110 - 7 + r]) wr(16'h0C00 + 16'(8 * r), 32'h8000_0000);
      for (int r = 0; r < 32; r++)
        if (VEC[v][71 + r]) wr(16'h1000 + 16'(8 * r), 32'h8000_0000);
      lines(VEC[v][70:7]);
      chk_req($sformatf("R4 R3 vector %0d", v), VEC[v][6], VEC[v][5:0]);
    end

    // R1 / R2 reset state and fixed bits
    do_reset();
    chk_req("R1 reset", 1'b0, 6'd0);
    rd(16'h0C18, d); check("R1 R2 slot reg 3", d, 32'h0000_07CC);
    rd(16'h1020, d); check("R1 R2 board reg 4", d, 32'h0000_07E4);
    wr(16'h0C18, 32'hFFFF_FFFF);
    rd(16'h0C18, d); check("R2 slot write only bit31", d, 32'h8000_07CC);
    wr(16'h1020, 32'h7FFF_0000);
    rd(16'h1020, d); check("R2 board write zero enable", d, 32'h0000_07E4);

    // R5 / R7 / R9 on-board sequence
    do_reset();
    wr(16'h1000, 32'h8000_0000);
    wr(16'h1008, 32'h8000_0000);
    lines(64'h0000_0002_0000_0000);
    chk_req("R4 line 33", 1'b1, 6'd33);
    lines(64'h0000_0003_0000_0000);
    chk_req("R7 no board takeover", 1'b1, 6'd33);
    lines(64'h0000_0001_0000_0000);
    chk_req("R5 held after drop", 1'b1, 6'd33);
    wr(16'h1800, 32'h0); idle(2);
    chk_req("R9 mismatched clear", 1'b1, 6'd33);
    wr(16'h1808, 32'h0); idle(1);
    chk_req("R9 clear then reselect 32", 1'b1, 6'd32);
    lines(64'h0);
    wr(16'h1800, 32'h0); idle(2);
    chk_req("R9 clear retires", 1'b0, 6'd0);

    // R6 / R8 slot sequence
    lines(64'h0000_0001_0000_0000);
    chk_req("R4 line 32 again", 1'b1, 6'd32);
    wr(16'h0C08, 32'h8000_0000);
    lines(64'h0000_0001_0000_0020);
    chk_req("R6 slot takeover", 1'b1, 6'd5);
    lines(64'h0000_0000_0000_0000);
    wr(16'h1400, 32'h0); idle(2);
    chk_req("R8 wrong group", 1'b1, 6'd5);
    wr(16'h1420, 32'h0); idle(2);
    chk_req("R8 group clear", 1'b0, 6'd0);

    // R10 disable clears only owner
    lines(64'h0000_0000_0000_0040);
    chk_req("R6 line 6", 1'b1, 6'd6);
    wr(16'h0C00, 32'h0); idle(2);
    chk_req("R10 other register", 1'b1, 6'd6);
    wr(16'h0C08, 32'h0); idle(2);
    chk_req("R10 owner disabled", 1'b0, 6'd0);
    rd(16'h0C08, d); check("R10 R2 reg1 readback", d, 32'h0000_07C4);

    // R11 read of clear windows
    rd(16'h1400, d); check("R11 slot clear read", d, 32'h0);
    rd(16'h1808, d); check("R11 board clear read", d, 32'h0);
    rd(16'h2000, d); check("R11 unmapped read", d, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule